// File: doc/BRIEF.md
# Periodic Interval Timer

A memory-mapped timer that raises a periodic event. A prescaler divides the clock by sixteen. Each prescaled tick advances a 20-bit count, which wraps to zero after it reaches the programmed interval. Each wrap sets an event flag and bumps a 12-bit overflow tally. A level interrupt follows the flag when interrupts are enabled.

Software reaches the block through a simple single-cycle register port. It can read the counter state through two windows. The acknowledging window clears the flag and the tally. The image window leaves both untouched, so the counter can serve as a free-running time base. Clearing the enable bit does not stop the counter at once: it stops only when the count next returns to zero.

Top module: `interval_timer`

## Requirements
- R1: After reset, word 0 reads 0x000FFFFF, and words 1, 2 and 3 read 0. `irq_o` is low and the counter is stopped.
- R2: Word 0 (mode) takes the interval in bits 19:0, run-enable in bit 24 and interrupt-enable in bit 25. All other bits read back as zero.
- R3: While running, the current count (bits 19:0 of words 2 and 3) advances once every 16 clock cycles. It goes to 0 on the tick after it equals the interval, so one period is (interval+1)*16 cycles.
- R4: Every wrap sets the event flag (word 1, bit 0) and adds one to the overflow tally (bits 31:20 of words 2 and 3).
- R5: A read of word 2 returns {tally, count} as they were before the read. It then clears the flag and the tally.
- R6: A read of word 3 returns the same fields and changes neither the flag nor the tally.
- R7: `irq_o` is high exactly while the flag and interrupt-enable are both set. The counter runs and sets the flag even when interrupt-enable is 0.
- R8: When run-enable is cleared, the counter keeps advancing until the count is 0, and then it stays at 0.
- R9: The tally stops at 4095 instead of wrapping.
- R10: When a wrap and a word-2 read fall in the same cycle, the flag stays set and the tally becomes 1.
- R11: Writes to words 1, 2 and 3 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word index: 0 mode, 1 status, 2 acknowledging value, 3 image |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered one cycle after the request |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is registered, so it appears in the cycle after the edge that samples the request. Side effects of a word-2 read land on that same edge, which makes `irq_o` fall one cycle after the request. A mode write takes effect on its sampling edge, and the first count step comes 16 edges after an enable from rest. The bench runs a cycle-level model on the same edges, samples on the falling edge, and compares each read in the cycle after its request. It also compares `irq_o` on every cycle. Directed cases aim at the exact wrap edge to hit the read collision, and wait for saturation with a zero interval.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 20;
  localparam int OVF_W   = 12;
  localparam int EN_BIT  = 24;
  localparam int IEN_BIT = 25;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_STAT = 2'd1,
    REG_VAL  = 2'd2,
    REG_IMG  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             ien;
    logic             en;
    logic [CNT_W-1:0] piv;
  } mode_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign tick_o = run_i;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (!run_i)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic [W-1:0] piv_i,
  output logic [W-1:0] cur_o,
  output logic         wrap_o,
  output logic         run_o
);
  logic [W-1:0] cur_q;
  logic         at_top;

  assign at_top = (cur_q == piv_i);
  assign wrap_o = tick_i && at_top;
  // keeps running after disable until the count is back at zero
  assign run_o  = en_i || (cur_q != '0);
  assign cur_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (tick_i) cur_q <= at_top ? '0 : cur_q + 1'b1;
  end
endmodule

// File: rtl/pit_event.sv
module pit_event #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wrap_i,
  input  logic         ack_i,
  output logic         flag_o,
  output logic [W-1:0] ovf_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic         flag_q;
  logic [W-1:0] ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ovf_q  <= '0;
    end else if (wrap_i) begin
      // a wrap in the ack cycle survives the ack
      flag_q <= 1'b1;
      if (ack_i)             ovf_q <= W'(1);
      else if (ovf_q != MAX) ovf_q <= ovf_q + 1'b1;
    end else if (ack_i) begin
      flag_q <= 1'b0;
      ovf_q  <= '0;
    end
  end

  assign flag_o = flag_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import pit_pkg::*;
#(
  parameter int PRESCALE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  mode_t             mode_q;
  logic              mode_wr, val_rd, img_rd, rd_en;
  logic              tick, wrap, run;
  logic [CNT_W-1:0]  cur;
  logic              flag;
  logic [OVF_W-1:0]  ovf;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:IEN_BIT+1], wdata_i[EN_BIT-1:CNT_W]};

  assign rd_en   = req_i && !we_i;
  assign mode_wr = req_i && we_i && (reg_sel_e'(addr_i) == REG_MODE);
  assign val_rd  = rd_en && (reg_sel_e'(addr_i) == REG_VAL);
  assign img_rd  = rd_en && (reg_sel_e'(addr_i) == REG_IMG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '{ien: 1'b0, en: 1'b0, piv: '1};
    end else if (mode_wr) begin
      mode_q <= '{ien: wdata_i[IEN_BIT], en: wdata_i[EN_BIT], piv: wdata_i[CNT_W-1:0]};
    end
  end

  pit_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  pit_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .en_i  (mode_q.en),
    .piv_i (mode_q.piv),
    .cur_o (cur),
    .wrap_o(wrap),
    .run_o (run)
  );

  pit_event #(.W(OVF_W)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_i(wrap),
    .ack_i (val_rd),
    .flag_o(flag),
    .ovf_o (ovf)
  );

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(addr_i))
      REG_MODE: begin
        rd_mux[CNT_W-1:0] = mode_q.piv;
        rd_mux[EN_BIT]    = mode_q.en;
        rd_mux[IEN_BIT]   = mode_q.ien;
      end
      REG_STAT: rd_mux[0] = flag;
      REG_VAL, REG_IMG: rd_mux = {ovf, cur};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = flag && mode_q.ien;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W = 20,
  parameter int OVF_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             ien,
  input logic             en,
  input logic             mode_wr,
  input logic             wrap,
  input logic             val_rd,
  input logic             img_rd,
  input logic             flag,
  input logic [OVF_W-1:0] ovf,
  input logic [CNT_W-1:0] cur
);
  localparam logic [OVF_W-1:0] MAX = {OVF_W{1'b1}};

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur != $past(cur)) |-> (cur == $past(cur) + 1'b1 || cur == '0));

  p_flag_on_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag);

  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_rd && !wrap) |=> (!flag && ovf == '0));

  p_image_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_rd && !wrap) |=> ($stable(flag) && $stable(ovf)));

  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien |-> !irq_o);

  p_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && cur == '0 && !mode_wr) |=> (cur == '0));

  p_saturate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf == MAX && !val_rd) |=> (ovf == MAX));

  p_collide_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && val_rd) |=> (flag && ovf == OVF_W'(1)));
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(pit_pkg::CNT_W), .OVF_W(pit_pkg::OVF_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_o  (irq_o),
  .ien    (mode_q.ien),
  .en     (mode_q.en),
  .mode_wr(mode_wr),
  .wrap   (wrap),
  .val_rd (val_rd),
  .img_rd (img_rd),
  .flag   (flag),
  .ovf    (ovf),
  .cur    (cur)
);

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // bench model built from the requirements
  logic [3:0]  m_pre;
  logic [19:0] m_cur, m_piv;
  logic        m_en, m_ien, m_flag;
  logic [11:0] m_ovf;
  logic [31:0] m_rd;

  function automatic logic m_run();
    return m_en || (m_cur != 20'd0);
  endfunction

  function automatic logic wrap_next();
    return m_run() && m_pre == 4'd15 && m_cur == m_piv;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {6'd0, m_ien, m_en, 4'd0, m_piv};
      2'd1:    return {31'd0, m_flag};
      default: return {m_ovf, m_cur};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= '0; m_cur <= '0; m_piv <= '1; m_en <= 0; m_ien <= 0;
      m_flag <= 0; m_ovf <= '0; m_rd <= '0;
    end else begin
      logic tk, wr, ack;
      tk  = m_run() && m_pre == 4'd15;
      wr  = tk && m_cur == m_piv;
      ack = req && !we && addr == 2'd2;
      m_pre <= m_run() ? m_pre + 4'd1 : 4'd0;
      if (tk) m_cur <= wr ? 20'd0 : m_cur + 20'd1;
      if (wr) begin
        m_flag <= 1'b1;
        m_ovf  <= ack ? 12'd1 : (m_ovf == 12'hFFF ? m_ovf : m_ovf + 12'd1);
      end else if (ack) begin
        m_flag <= 1'b0; m_ovf <= '0;
      end
      if (req && we && addr == 2'd0) begin
        m_piv <= wdata[19:0]; m_en <= wdata[24]; m_ien <= wdata[25];
      end
      if (req && !we) m_rd <= exp_read(addr);
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    string tag;
    req = 1; we = 0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 0;
    d = rdata;
    case (a)
      2'd0: tag = "R2 mode";
      2'd1: tag = "R4 status";
      2'd2: tag = "R5 value";
      default: tag = "R6 image";
    endcase
    check(tag, d, m_rd);
  endtask

  // R7: interrupt level compared every cycle
  always @(negedge clk) if (rst_n && !done) check("R7 irq", {31'd0, irq}, {31'd0, m_flag & m_ien});

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, d); check("R1 mode", d, 32'h000FFFFF);
    rd_reg(2'd1, d); check("R1 status", d, 32'h0);
    rd_reg(2'd2, d); check("R1 value", d, 32'h0);
    rd_reg(2'd3, d); check("R1 image", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R2 field packing, R11 ignored writes
    wr_reg(2'd0, 32'h4012_3456 | 32'h0012_0000);
    rd_reg(2'd0, d); check("R2 readback", d, 32'h0002_3456);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_reg(2'd0, d); check("R11 mode kept", d, 32'h0002_3456);
    rd_reg(2'd1, d); check("R11 status kept", d, 32'h0);
    rd_reg(2'd3, d); check("R11 count kept", d, 32'h0);

    // R3 rate: enable with interval 7, ~56 cycles later count is 3
    wr_reg(2'd0, 32'h0100_0007);
    repeat (56) @(negedge clk);
    rd_reg(2'd3, d); check("R3 count rate", d, 32'h0000_0003);

    // R4/R7 flag with interrupts off, then irq when enabled
    repeat (256) @(negedge clk);
    rd_reg(2'd1, d); check("R4 flag set", d, 32'h1);
    check("R7 irq off when masked", {31'd0, irq}, 32'h0);
    wr_reg(2'd0, 32'h0300_0007);
    check("R7 irq on", {31'd0, irq}, 32'h1);
    rd_reg(2'd3, d); check("R6 tally nonzero", {31'd0, d[31:20] != 0}, 32'h1);
    rd_reg(2'd3, d);
    rd_reg(2'd2, d);
    rd_reg(2'd1, d); check("R5 flag cleared", d, {31'd0, m_flag});

    // R10 ack on the wrap edge
    while (!wrap_next()) @(negedge clk);
    rd_reg(2'd2, d);
    rd_reg(2'd1, d); check("R10 flag kept", d, 32'h1);
    rd_reg(2'd3, d); check("R10 tally one", {20'd0, d[31:20]}, 32'h1);

    // R8 disable runs out to zero then holds
    while (m_cur != 20'd4) @(negedge clk);
    wr_reg(2'd0, 32'h0200_0007);
    rd_reg(2'd3, d); check("R8 still running", {31'd0, d[19:0] != 0}, 32'h1);
    repeat (160) @(negedge clk);
    rd_reg(2'd3, d); check("R8 stopped at zero", {12'd0, d[19:0]}, 32'h0);
    repeat (100) @(negedge clk);
    rd_reg(2'd3, d); check("R8 holds zero", {12'd0, d[19:0]}, 32'h0);

    // R9 saturation with interval 0
    wr_reg(2'd0, 32'h0100_0000);
    repeat (4100 * 16) @(negedge clk);
    rd_reg(2'd3, d); check("R9 saturated", {20'd0, d[31:20]}, 32'h0000_0FFF);
    rd_reg(2'd2, d); check("R9 ack returns max", {20'd0, d[31:20]}, 32'h0000_0FFF);

    // random mix, interval fixed while running
    wr_reg(2'd0, 32'h0100_0005);
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      if (op == 5)
        wr_reg(2'd0, {6'd0, 1'($urandom), 1'($urandom), 4'd0, m_piv});
      else
        rd_reg(2'($urandom_range(0, 3)), d);
      repeat ($urandom_range(0, 30)) @(negedge clk);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule